// File: doc/BRIEF.md
# Three-Wire Serial Memory Slave Front End

This block is the serial command front end of a small word-organised nonvolatile memory. A host drives a chip select, a serial clock and a serial data line. The block finds the start bit, collects a two-bit opcode, an address and, for writes, a data word. It then does one of three things: it hands a decoded program command to a separate program sequencer, it asks the storage array for a word and shifts it back out, or it changes its own write-enable latch. The data output is modelled as a data bit together with an output enable.

A width-select input chooses between 8-bit and 16-bit words, and this changes the length of the address field. Once a program command has been issued, the host can drop chip select and raise it again to poll the sequencer. The data output then shows whether the sequencer is still busy or is ready. All serial inputs are sampled in the block's own clock domain. A serial rising edge is seen as a change from low to high between two system clock samples.

Top module: `uwire_slave_if`

## Requirements
- R1: A start condition is the first serial clock rise at which chip select and sdi are both high. Rises with sdi low before it have no effect.
- R2: The two bits after the start bit give the opcode. 10 is read, 01 is write and 11 is erase. For opcode 00, the two most significant address bits select the action: 11 sets the write-enable latch, 00 clears it, 10 is erase-all and 01 is write-all (which takes a data word).
- R3: When org_x16 is 1, the address is 6 bits and the data word is 16 bits, so instructions take 9 or 25 serial clocks counting the start bit. When org_x16 is 0, the address is 7 bits and the data word is 8 bits, so instructions take 10 or 18 serial clocks.
- R4: A program command is issued only after its last bit has been clocked in. It appears as a one-cycle prg_valid pulse carrying prg_op (0 write, 1 erase, 2 write-all, 3 erase-all), the received address field and, for writes, the data.
- R5: The write-enable latch is clear after reset and is not affected by chip select. Any program command received while the latch is clear produces no request.
- R6: A read raises mem_rd for one cycle with the address after the last address bit. sdo_oe then rises and sdo shows a dummy zero. Each following serial rise shifts out one data bit, most significant bit first. In 8-bit mode the data comes from mem_rdata[7:0]. The array must answer (mem_rvalid) before the next serial rise.
- R7: Once an instruction has completed, further serial clocks and sdi values are ignored until chip select goes low. After a read has shifted out its last bit, sdo_oe falls at the next serial rise.
- R8: While chip select is low, sdo_oe is low and the framing logic returns to idle. An instruction cut short by chip select falling has no effect.
- R9: After a program request, if chip select is raised again, sdo_oe is high before any start bit and sdo equals the inverse of prg_busy. The next start bit ends this status display.
- R10: In 8-bit mode, write and write-all data appear on prg_data zero-extended to the full word width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip select, active high |
| sck | input | 1 | Serial clock, sampled by clk |
| sdi | input | 1 | Serial data in |
| org_x16 | input | 1 | 1 selects 16-bit words, 0 selects 8-bit words |
| sdo | output | 1 | Serial data out bit |
| sdo_oe | output | 1 | Output enable for sdo |
| mem_rd | output | 1 | One-cycle read request to the array |
| mem_raddr | output | AW16+1 | Read address |
| mem_rvalid | input | 1 | Read data valid from the array |
| mem_rdata | input | DW | Read data word |
| prg_valid | output | 1 | One-cycle program request |
| prg_op | output | 2 | Program operation code |
| prg_addr | output | AW16+1 | Program address field |
| prg_data | output | DW | Program data |
| prg_busy | input | 1 | Sequencer busy flag |

## Verification
The assertions rely on a few things about the inputs. sck, sdi and cs must be synchronous to clk, and each serial level must be held for more than one clk cycle so that each serial rise is counted once. The read answer must arrive within the serial half-period after mem_rd. The stimulus drives all inputs on the falling edge of clk. It holds every serial phase for two clk cycles and keeps cs low for two cycles between instructions. Its array model answers one cycle after mem_rd, well before the next serial rise.

// File: rtl/sio_pkg.sv
package sio_pkg;

  typedef enum logic [1:0] {
    PRG_WRITE = 2'd0,
    PRG_ERASE = 2'd1,
    PRG_WRAL  = 2'd2,
    PRG_ERAL  = 2'd3
  } prg_op_t;

  typedef enum logic [1:0] {
    FR_IDLE,
    FR_SHIFT,
    FR_RDOUT,
    FR_DONE
  } fr_state_t;

  // address field length for the selected word width
  function automatic int addr_bits(input logic x16, input int aw16);
    return x16 ? aw16 : aw16 + 1;
  endfunction

  // data field length for the selected word width
  function automatic int data_bits(input logic x16, input int dw);
    return x16 ? dw : dw / 2;
  endfunction

endpackage

// File: rtl/sio_edge.sv
module sio_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  output logic rise
);
  logic sck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_q <= 1'b0;
    else        sck_q <= sck;
  end

  assign rise = sck & ~sck_q;
endmodule

// File: rtl/sio_frame.sv
module sio_frame
  import sio_pkg::*;
#(
  parameter int AW16 = 6,
  parameter int DW   = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs,
  input  logic            rise,
  input  logic            sdi,
  input  logic            org_x16,
  output fr_state_t       state,
  output logic            start_evt,
  output logic            rd_launch,
  output logic            rd_shift,
  output logic            rd_first,
  output logic            wen,
  output logic            stat_pend,
  output logic            mem_rd,
  output logic [AW16:0]   mem_raddr,
  output logic            prg_valid,
  output prg_op_t         prg_op,
  output logic [AW16:0]   prg_addr,
  output logic [DW-1:0]   prg_data
);
  localparam int AW = AW16 + 1;
  localparam int CW = $clog2(3 + AW + DW);

  logic [CW-1:0] cnt;
  logic [1:0]    op_q, op_n;
  logic [AW-1:0] addr_q, addr_n;
  logic [DW-1:0] data_q, data_n;
  logic [1:0]    sub;
  logic [CW-1:0] hdr_last, dat_last, dlen;
  logic          shifting, hdr_end, dat_end;
  logic          dec_prg, dec_done, dec_wen_set, dec_wen_clr;
  prg_op_t       dec_op;

  assign hdr_last = CW'(1 + addr_bits(org_x16, AW16));
  assign dlen     = CW'(data_bits(org_x16, DW));
  assign dat_last = hdr_last + dlen;

  assign op_n   = {op_q[0], sdi};
  assign addr_n = {addr_q[AW-2:0], sdi};
  assign data_n = {data_q[DW-2:0], sdi};
  assign sub    = org_x16 ? addr_n[AW16-1 -: 2] : addr_n[AW16 -: 2];

  assign start_evt = cs && rise && (state == FR_IDLE) && sdi;
  assign shifting  = cs && rise && (state == FR_SHIFT);
  assign hdr_end   = shifting && (cnt == hdr_last);
  assign dat_end   = shifting && (cnt == dat_last);
  assign rd_launch = hdr_end && (op_q == 2'b10);
  assign rd_shift  = cs && rise && (state == FR_RDOUT) && (cnt != dlen);
  assign rd_first  = (cnt == '0);

  always_comb begin
    dec_prg     = 1'b0;
    dec_done    = 1'b0;
    dec_wen_set = 1'b0;
    dec_wen_clr = 1'b0;
    dec_op      = PRG_WRITE;
    if (hdr_end) begin
      unique case (op_q)
        2'b11: begin dec_prg = 1'b1; dec_op = PRG_ERASE; dec_done = 1'b1; end
        2'b00: begin
          unique case (sub)
            2'b11: begin dec_wen_set = 1'b1; dec_done = 1'b1; end
            2'b00: begin dec_wen_clr = 1'b1; dec_done = 1'b1; end
            2'b10: begin dec_prg = 1'b1; dec_op = PRG_ERAL; dec_done = 1'b1; end
            default: ;
          endcase
        end
        default: ;
      endcase
    end
    if (dat_end) begin
      dec_prg  = 1'b1;
      dec_op   = (op_q == 2'b01) ? PRG_WRITE : PRG_WRAL;
      dec_done = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= FR_IDLE;
      cnt       <= '0;
      op_q      <= '0;
      addr_q    <= '0;
      data_q    <= '0;
      wen       <= 1'b0;
      stat_pend <= 1'b0;
      mem_rd    <= 1'b0;
      mem_raddr <= '0;
      prg_valid <= 1'b0;
      prg_op    <= PRG_WRITE;
      prg_addr  <= '0;
      prg_data  <= '0;
    end else begin
      mem_rd    <= 1'b0;
      prg_valid <= 1'b0;
      if (dec_prg && wen) begin
        prg_valid <= 1'b1;
        prg_op    <= dec_op;
        prg_addr  <= hdr_end ? addr_n : addr_q;
        prg_data  <= dat_end ? data_n : '0;
        stat_pend <= 1'b1;
      end else if (start_evt) begin
        stat_pend <= 1'b0;
      end
      if (dec_wen_set)      wen <= 1'b1;
      else if (dec_wen_clr) wen <= 1'b0;
      if (rd_launch) begin
        mem_rd    <= 1'b1;
        mem_raddr <= addr_n;
      end
      if (!cs) begin
        state <= FR_IDLE;
        cnt   <= '0;
      end else if (rise) begin
        unique case (state)
          FR_IDLE: if (sdi) begin
            state  <= FR_SHIFT;
            cnt    <= '0;
            op_q   <= '0;
            addr_q <= '0;
            data_q <= '0;
          end
          FR_SHIFT: begin
            cnt <= cnt + CW'(1);
            if (cnt < CW'(2))         op_q   <= op_n;
            else if (cnt <= hdr_last) addr_q <= addr_n;
            else                      data_q <= data_n;
            if (rd_launch) begin
              state <= FR_RDOUT;
              cnt   <= '0;
            end else if (dec_done) begin
              state <= FR_DONE;
            end
          end
          FR_RDOUT: begin
            if (cnt == dlen) state <= FR_DONE;
            else             cnt   <= cnt + CW'(1);
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/sio_rdshift.sv
module sio_rdshift #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          shift,
  input  logic          first,
  input  logic          org_x16,
  input  logic          rvalid,
  input  logic [DW-1:0] rdata,
  output logic          bit_o
);
  localparam int HW = DW / 2;

  logic [DW-1:0] rbuf, osr, loaded;

  assign loaded = org_x16 ? rbuf : {rbuf[HW-1:0], {(DW-HW){1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbuf <= '0;
      osr  <= '0;
    end else begin
      if (rvalid) rbuf <= rdata;
      if (clear)      osr <= '0;
      else if (shift) osr <= first ? loaded : {osr[DW-2:0], 1'b0};
    end
  end

  assign bit_o = osr[DW-1];
endmodule

// File: rtl/sio_dout.sv
module sio_dout
  import sio_pkg::*;
(
  input  logic      cs,
  input  fr_state_t state,
  input  logic      stat_pend,
  input  logic      rd_bit,
  input  logic      prg_busy,
  output logic      sdo,
  output logic      sdo_oe
);
  logic reading;

  assign reading = (state == FR_RDOUT);
  assign sdo_oe  = cs && (reading || ((state == FR_IDLE) && stat_pend));
  assign sdo     = reading ? rd_bit : ~prg_busy;
endmodule

// File: rtl/uwire_slave_if.sv
module uwire_slave_if
  import sio_pkg::*;
#(
  parameter int AW16 = 6,
  parameter int DW   = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs,
  input  logic            sck,
  input  logic            sdi,
  input  logic            org_x16,
  output logic            sdo,
  output logic            sdo_oe,
  output logic            mem_rd,
  output logic [AW16:0]   mem_raddr,
  input  logic            mem_rvalid,
  input  logic [DW-1:0]   mem_rdata,
  output logic            prg_valid,
  output logic [1:0]      prg_op,
  output logic [AW16:0]   prg_addr,
  output logic [DW-1:0]   prg_data,
  input  logic            prg_busy
);
  fr_state_t state;
  prg_op_t   prg_op_e;
  logic      rise, start_evt, rd_launch, rd_shift, rd_first;
  logic      wen, stat_pend, rd_bit, fr_idle;

  sio_edge u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .sck   (sck),
    .rise  (rise)
  );

  sio_frame #(.AW16(AW16), .DW(DW)) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs        (cs),
    .rise      (rise),
    .sdi       (sdi),
    .org_x16   (org_x16),
    .state     (state),
    .start_evt (start_evt),
    .rd_launch (rd_launch),
    .rd_shift  (rd_shift),
    .rd_first  (rd_first),
    .wen       (wen),
    .stat_pend (stat_pend),
    .mem_rd    (mem_rd),
    .mem_raddr (mem_raddr),
    .prg_valid (prg_valid),
    .prg_op    (prg_op_e),
    .prg_addr  (prg_addr),
    .prg_data  (prg_data)
  );

  sio_rdshift #(.DW(DW)) u_rdshift (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (rd_launch),
    .shift   (rd_shift),
    .first   (rd_first),
    .org_x16 (org_x16),
    .rvalid  (mem_rvalid),
    .rdata   (mem_rdata),
    .bit_o   (rd_bit)
  );

  sio_dout u_dout (
    .cs        (cs),
    .state     (state),
    .stat_pend (stat_pend),
    .rd_bit    (rd_bit),
    .prg_busy  (prg_busy),
    .sdo       (sdo),
    .sdo_oe    (sdo_oe)
  );

  assign prg_op  = prg_op_e;
  assign fr_idle = (state == FR_IDLE);
endmodule

// File: rtl/uwire_slave_chk.sv
module uwire_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic cs,
  input logic sdo,
  input logic sdo_oe,
  input logic mem_rd,
  input logic prg_valid,
  input logic wen,
  input logic start_evt,
  input logic fr_idle
);
  assert_cs_low_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |-> !sdo_oe);

  assert_cs_low_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |=> fr_idle);

  assert_prg_needs_wen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    prg_valid |-> $past(wen));

  assert_prg_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    prg_valid |=> !prg_valid);

  assert_rd_dummy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && cs) |-> (sdo_oe && !sdo));

  assert_rd_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd);

  assert_start_ends_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !sdo_oe);
endmodule

bind uwire_slave_if uwire_slave_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs        (cs),
  .sdo       (sdo),
  .sdo_oe    (sdo_oe),
  .mem_rd    (mem_rd),
  .prg_valid (prg_valid),
  .wen       (wen),
  .start_evt (start_evt),
  .fr_idle   (fr_idle)
);

// File: tb/tb_uwire_slave_if.sv
`timescale 1ns/1ps
module tb_uwire_slave_if;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, sck = 1'b0, sdi = 1'b0, org_x16 = 1'b1;
  logic sdo, sdo_oe, mem_rd, prg_valid;
  logic [6:0] mem_raddr, prg_addr;
  logic [1:0] prg_op;
  logic [15:0] prg_data;
  logic mem_rvalid = 1'b0;
  logic [15:0] mem_rdata = '0;
  logic prg_busy = 1'b0;

  always #2.5 clk = ~clk;

  uwire_slave_if dut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sck(sck), .sdi(sdi), .org_x16(org_x16),
    .sdo(sdo), .sdo_oe(sdo_oe), .mem_rd(mem_rd), .mem_raddr(mem_raddr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .prg_valid(prg_valid),
    .prg_op(prg_op), .prg_addr(prg_addr), .prg_data(prg_data), .prg_busy(prg_busy)
  );

  int checks = 0, fails = 0;
  string cur_req = "R8";
  bit mon_en = 0, finished = 0;

  // reference model state
  int m_mode = 0;          // 0 idle, 1 collecting, 2 reading out, 3 finished
  bit m_pend = 0, m_wen = 0, m_out = 0;
  bit m_bits[$];
  bit m_rq[$];
  int m_raddr[$];
  int eq_op[$], eq_addr[$], eq_data[$];

  function automatic logic [15:0] memval(input int a);
    return 16'(a * 1031 + 16'h1234);
  endfunction

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  task automatic expect_prg(input int op, input int a, input int d);
    if (m_wen) begin
      eq_op.push_back(op); eq_addr.push_back(a); eq_data.push_back(d);
      m_pend = 1;
    end
  endtask

  task automatic m_edge(input bit b);
    int al, dl, n, a, d;
    logic [1:0] opc;
    logic [15:0] w;
    al = org_x16 ? 6 : 7;
    dl = org_x16 ? 16 : 8;
    case (m_mode)
      0: if (b) begin m_mode = 1; m_bits.delete(); m_pend = 0; end
      1: begin
        m_bits.push_back(b);
        n = m_bits.size();
        opc = (n >= 2) ? {m_bits[0], m_bits[1]} : 2'b00;
        a = 0;
        for (int i = 2; i < n && i < 2 + al; i++) a = a * 2 + int'(m_bits[i]);
        if (n == 2 + al) begin
          if (opc == 2'b10) begin
            m_mode = 2; m_out = 0; w = memval(a);
            m_rq.delete();
            for (int i = dl - 1; i >= 0; i--) m_rq.push_back(w[i]);
            m_raddr.push_back(a);
          end else if (opc == 2'b11) begin
            expect_prg(1, a, 0); m_mode = 3;
          end else if (opc == 2'b00) begin
            case (a >> (al - 2))
              3: begin m_wen = 1; m_mode = 3; end
              0: begin m_wen = 0; m_mode = 3; end
              2: begin expect_prg(3, a, 0); m_mode = 3; end
              default: ;
            endcase
          end
        end else if (n == 2 + al + dl) begin
          d = 0;
          for (int i = 2 + al; i < n; i++) d = d * 2 + int'(m_bits[i]);
          expect_prg((opc == 2'b01) ? 0 : 2, a, d);
          m_mode = 3;
        end
      end
      2: if (m_rq.size() == 0) m_mode = 3; else m_out = m_rq.pop_front();
      default: ;
    endcase
  endtask

  // one serial clock: data set, rise, hold, fall
  task automatic sbit(input bit b);
    @(negedge clk); sdi = b;
    @(negedge clk); sck = 1'b1;
    @(posedge clk); #1;
    if (cs) m_edge(b);
    @(negedge clk); @(negedge clk); sck = 1'b0;
  endtask

  task automatic cs_low();
    @(negedge clk); cs = 1'b0; m_mode = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic cs_high();
    @(negedge clk); cs = 1'b1;
  endtask

  task automatic instr(input logic [1:0] op, input int addr, input int data, input bit with_data);
    int al, dl;
    al = org_x16 ? 6 : 7;
    dl = org_x16 ? 16 : 8;
    sbit(1); sbit(op[1]); sbit(op[0]);
    for (int i = al - 1; i >= 0; i--) sbit(addr[i]);
    if (with_data) for (int i = dl - 1; i >= 0; i--) sbit(data[i]);
  endtask

  task automatic idle_clocks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic end_step();
    idle_clocks(2);
    chk(eq_op.size() == 0, "program request still missing", eq_op.size(), 0);
  endtask

  // per-clock comparison against the model
  always @(posedge clk) begin
    bit e_oe, e_do;
    #2;
    mem_rvalid = 1'b0;
    if (mon_en) begin
      e_oe = cs && (m_mode == 2 || (m_mode == 0 && m_pend));
      e_do = (m_mode == 2) ? m_out : !prg_busy;
      chk(sdo_oe === e_oe, "sdo_oe", int'(sdo_oe), int'(e_oe));
      if (e_oe) chk(sdo === e_do, "sdo", int'(sdo), int'(e_do));
      if (prg_valid) begin
        if (eq_op.size() == 0) chk(0, "unexpected prg_valid", 1, 0);
        else begin
          chk(int'(prg_op) == eq_op[0], "prg_op", int'(prg_op), eq_op[0]);
          chk(int'(prg_addr) == eq_addr[0], "prg_addr", int'(prg_addr), eq_addr[0]);
          chk(int'(prg_data) == eq_data[0], "prg_data", int'(prg_data), eq_data[0]);
          void'(eq_op.pop_front()); void'(eq_addr.pop_front()); void'(eq_data.pop_front());
        end
      end
      if (mem_rd) begin
        if (m_raddr.size() == 0) chk(0, "unexpected mem_rd", 1, 0);
        else chk(int'(mem_raddr) == m_raddr.pop_front(), "mem_raddr", int'(mem_raddr), 0);
        mem_rvalid = 1'b1;
        mem_rdata = memval(int'(mem_raddr));
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    cur_req = "R8";
    chk(sdo_oe === 1'b0, "reset sdo_oe", int'(sdo_oe), 0);
    chk(prg_valid === 1'b0, "reset prg_valid", int'(prg_valid), 0);
    chk(mem_rd === 1'b0, "reset mem_rd", int'(mem_rd), 0);
    mon_en = 1;

    // R5: write while latch clear, 16-bit mode
    cur_req = "R5";
    cs_high(); instr(2'b01, 6'h2A, 16'hBEEF, 1); end_step(); cs_low();

    // R2 enable, then R7 extra ones ignored (would be an erase frame)
    cur_req = "R7";
    cs_high(); instr(2'b00, 6'b110000, 0, 0);
    for (int i = 0; i < 10; i++) sbit(1);
    end_step(); cs_low();

    // R4 / R3: 16-bit write, 25 clocks
    cur_req = "R4";
    cs_high(); instr(2'b01, 6'h2A, 16'hBEEF, 1); end_step(); cs_low();

    // R9 status display
    cur_req = "R9";
    prg_busy = 1'b1;
    cs_high(); idle_clocks(4);
    @(negedge clk); prg_busy = 1'b0;
    idle_clocks(4);
    cs_low();
    cs_high(); idle_clocks(3);

    // R6 read in 16-bit mode, start bit ends status
    cur_req = "R6";
    instr(2'b10, 6'h15, 0, 0);
    for (int i = 0; i < 20; i++) sbit(i[0]);
    end_step(); cs_low();

    // R1 leading zeros ignored, then erase
    cur_req = "R1";
    cs_high(); sbit(0); sbit(0); sbit(0);
    instr(2'b11, 6'h3F, 0, 0); end_step(); cs_low();

    // R3 8-bit read
    @(negedge clk); org_x16 = 1'b0;
    cur_req = "R3";
    cs_high(); instr(2'b10, 7'h55, 0, 0);
    for (int i = 0; i < 12; i++) sbit(1);
    end_step(); cs_low();

    // R10 write-all and write in 8-bit mode, R2 erase-all
    cur_req = "R10";
    cs_high(); instr(2'b00, 7'b0100000, 8'hA7, 1); end_step(); cs_low();
    cs_high(); instr(2'b01, 7'h7E, 8'h3C, 1); end_step(); cs_low();
    cur_req = "R2";
    cs_high(); instr(2'b00, 7'b1000000, 0, 0); end_step(); cs_low();
    cs_high(); instr(2'b11, 7'h7F, 0, 0); end_step(); cs_low();

    // R8 truncated write dropped
    cur_req = "R8";
    cs_high();
    sbit(1); sbit(0); sbit(1); sbit(1); sbit(0); sbit(1); sbit(1);
    cs_low(); end_step();

    // R5 disable blocks later program commands
    cur_req = "R5";
    cs_high(); instr(2'b00, 7'b0000000, 0, 0); end_step(); cs_low();
    cs_high(); instr(2'b01, 7'h11, 8'h5A, 1); end_step(); cs_low();
    cs_high(); instr(2'b00, 7'b1000000, 0, 0); end_step(); cs_low();

    idle_clocks(4);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule